// File: doc/BRIEF.md
# Single-Wire Bus Transaction Master

This block drives one open-drain data line that an external resistor pulls high. It acts as the only master on that line. For each request it runs one complete layered transaction. The transaction opens with a long reset low followed by a window in which attached slaves may pull the line low to announce themselves. It then sends a one-byte device-level command, then a 64-bit device address if that command is the select code, then a one-byte memory-level command. Last comes a host-chosen number of data bytes, all read or all written.

The host loads the two command bytes, the address, the direction and the byte count, and pulses `start` while `ready` is high. Write bytes are pulled from the host with a valid/ready pair. Read bytes are offered with a valid/ready pair. At the end the block reports whether a slave answered and gives a one-cycle `done` pulse.

Every line time is counted in pulses of a clock-enable input `tick`, and each time is a parameter. Whenever the block waits for the host, the line stays released.

Top module: `owire_txn_master`

## Requirements
- R1: After synchronous reset, `ready` is 1 and `line_pull_low`, `done`, `wr_ready` and `rd_valid` are all 0.
- R2: A transaction starts by pulling the line low for RST_LOW ticks and then releasing it. `presence` becomes 1 if the line is low PRES_AT ticks after the release. The phase takes RST_LOW+RST_REST ticks in all.
- R3: If no slave answers, `no_device` becomes 1 and `done` pulses. No bit slot follows, and the line stays released.
- R4: Each bit slot begins with a falling edge and lasts SLOT_LEN ticks. A written 1 holds the line low for W1_LOW ticks and a written 0 holds it low for W0_LOW ticks. Successive slot starts are at least SLOT_LEN ticks apart.
- R5: Bytes go out least-significant bit first, and the device-level command comes first. When that command equals 0x55, the 64 address bits follow, starting with `addr[0]` and ending with `addr[63]`. Any other code sends no address.
- R6: The memory-level command follows, then `nbytes` data bytes. With `nbytes` = 0 the transaction ends right after the memory-level command.
- R7: In write mode (`rd_mode` = 0), each data byte is requested with `wr_ready`, taken on `wr_valid` & `wr_ready`, and sent least-significant bit first.
- R8: In read mode, a slot holds the line low for RD_LOW ticks, then samples it RD_AT ticks after the slot began. A high line is a 1. Bits fill the byte from bit 0 upward. The byte is shown on `rd_data` with `rd_valid` high and held steady until `rd_ready`.
- R9: While the block waits on `wr_valid` or `rd_ready`, no slot is issued and the line is released.
- R10: No pull-low inside a bit slot lasts MAX_LOW ticks (120) or longer.
- R11: `done` is a one-cycle pulse, and `ready` is 1 in the same cycle. A `start` present in that cycle is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable, one pulse per tick |
| start | input | 1 | Begin a transaction (taken while ready) |
| rom_cmd | input | 8 | Device-level command byte |
| mem_cmd | input | 8 | Memory-level command byte |
| addr | input | 64 | Device address sent after the select code |
| rd_mode | input | 1 | 1 = read data bytes, 0 = write data bytes |
| nbytes | input | LEN_W | Number of data bytes |
| ready | output | 1 | Idle and able to accept start |
| wr_data | input | 8 | Write byte from host |
| wr_valid | input | 1 | Write byte is valid |
| wr_ready | output | 1 | Block wants the next write byte |
| rd_data | output | 8 | Read byte to host |
| rd_valid | output | 1 | Read byte is valid |
| rd_ready | input | 1 | Host takes the read byte |
| line_in | input | 1 | Sampled level of the wire |
| line_pull_low | output | 1 | 1 = pull the wire low, 0 = release |
| presence | output | 1 | A slave answered the last reset |
| no_device | output | 1 | Last transaction aborted with no answer |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
Two things can meet in one cycle: the end-of-transaction pulse and the acceptance of the next request. `done` and `ready` are both high in that cycle, so a held `start` is taken immediately. The bench holds `start` high across the end of a transaction. In the `done` cycle it expects `ready` to be 1, and on the next sample it expects `ready` to be 0 with a fresh reset low of the full length following. The host stalls on write and read bytes are also stretched, and the bench judges that the wire stays released throughout those waits.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 8;
    localparam logic [BYTE_W-1:0] SELECT_CODE = 8'h55;

    typedef enum logic [1:0] {
        K_RESET,
        K_WR0,
        K_WR1,
        K_READ
    } slot_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST,
        S_ROM,
        S_ADDR,
        S_MEM,
        S_WFETCH,
        S_DATA,
        S_RHOLD
    } seq_state_e;

    function automatic logic is_select(input logic [BYTE_W-1:0] code);
        return code == SELECT_CODE;
    endfunction

    function automatic slot_kind_e write_kind(input logic b);
        return b ? K_WR1 : K_WR0;
    endfunction

endpackage

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
    import owm_pkg::*;
#(
    parameter int RST_LOW  = 480,
    parameter int RST_REST = 480,
    parameter int PRES_AT  = 70,
    parameter int SLOT_LEN = 70,
    parameter int W0_LOW   = 60,
    parameter int W1_LOW   = 6,
    parameter int RD_LOW   = 6,
    parameter int RD_AT    = 15,
    parameter int MAX_LOW  = 120
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       go,
    input  slot_kind_e kind,
    input  logic       line_in,
    output logic       drive_low,
    output logic       slot_done,
    output logic       bit_q,
    output logic       pres_q
);
    localparam int CW = $clog2(RST_LOW + RST_REST + MAX_LOW + 1);

    logic          active;
    slot_kind_e    kind_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] low_len;
    logic [CW-1:0] total;
    logic [CW-1:0] samp;
    logic [CW-1:0] lowrun;

    always_comb begin
        case (kind_q)
            K_RESET: begin
                low_len = CW'(RST_LOW);
                total   = CW'(RST_LOW + RST_REST);
                samp    = CW'(RST_LOW + PRES_AT);
            end
            K_WR0: begin
                low_len = CW'(W0_LOW);
                total   = CW'(SLOT_LEN);
                samp    = CW'(RD_AT);
            end
            K_WR1: begin
                low_len = CW'(W1_LOW);
                total   = CW'(SLOT_LEN);
                samp    = CW'(RD_AT);
            end
            default: begin
                low_len = CW'(RD_LOW);
                total   = CW'(SLOT_LEN);
                samp    = CW'(RD_AT);
            end
        endcase
    end

    assign drive_low = active && (cnt < low_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            kind_q    <= K_RESET;
            cnt       <= '0;
            slot_done <= 1'b0;
            bit_q     <= 1'b0;
            pres_q    <= 1'b0;
        end else begin
            slot_done <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                kind_q <= kind;
                cnt    <= '0;
                if (kind == K_RESET) pres_q <= 1'b0;
            end else if (active && tick) begin
                cnt <= cnt + 1'b1;
                if (cnt == samp) begin
                    if (kind_q == K_RESET) pres_q <= !line_in;
                    else if (kind_q == K_READ) bit_q <= line_in;
                end
                if (cnt == total - 1'b1) begin
                    active    <= 1'b0;
                    slot_done <= 1'b1;
                end
            end
        end
    end

    // length of the current pull-low inside a bit slot, in ticks
    always_ff @(posedge clk) begin
        if (rst || !drive_low || kind_q == K_RESET) lowrun <= '0;
        else if (tick) lowrun <= lowrun + 1'b1;
    end

    // R4
    slot_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> !active);

    // R10
    slot_low_limit_chk: assert property (@(posedge clk) disable iff (rst)
        lowrun < CW'(MAX_LOW));

    // R4
    slot_done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        slot_done |-> !drive_low);

endmodule

// File: rtl/owm_bit_shifter.sv
module owm_bit_shifter
    import owm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift,
    input  logic              shift_in,
    output logic [BYTE_W-1:0] q,
    output logic              last_bit
);
    localparam int BW = $clog2(BYTE_W);

    logic [BW-1:0] bitn;

    assign last_bit = (bitn == BW'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            bitn <= '0;
        end else if (load) begin
            q    <= load_val;
            bitn <= '0;
        end else if (shift) begin
            q    <= {shift_in, q[BYTE_W-1:1]};
            bitn <= bitn + 1'b1;
        end
    end

endmodule

// File: rtl/owire_txn_master.sv
module owire_txn_master
    import owm_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int RST_LOW  = 480,
    parameter int RST_REST = 480,
    parameter int PRES_AT  = 70,
    parameter int SLOT_LEN = 70,
    parameter int W0_LOW   = 60,
    parameter int W1_LOW   = 6,
    parameter int RD_LOW   = 6,
    parameter int RD_AT    = 15,
    parameter int MAX_LOW  = 120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic [7:0]        rom_cmd,
    input  logic [7:0]        mem_cmd,
    input  logic [63:0]       addr,
    input  logic              rd_mode,
    input  logic [LEN_W-1:0]  nbytes,
    output logic              ready,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    input  logic              line_in,
    output logic              line_pull_low,
    output logic              presence,
    output logic              no_device,
    output logic              done
);
    localparam int AW = $clog2(ADDR_BYTES);

    seq_state_e       st;
    logic             live;
    logic             sel_q;
    logic             rd_q;
    logic [7:0]       mem_q;
    logic [63:0]      addr_q;
    logic [AW-1:0]    abyte;
    logic [LEN_W-1:0] left;
    logic             done_q;
    logic             pres_hold;
    logic             nodev_q;

    logic             in_bits;
    logic             go;
    slot_kind_e       kind;
    logic             eng_done;
    logic             eng_bit;
    logic             eng_pres;
    logic             byte_end;

    logic             sh_load;
    logic [7:0]       sh_val;
    logic             sh_shift;
    logic [7:0]       sh_q;
    logic             sh_last;

    assign in_bits  = (st == S_ROM) || (st == S_ADDR) || (st == S_MEM) || (st == S_DATA);
    assign go       = (in_bits || st == S_RST) && !live;
    assign byte_end = in_bits && eng_done && sh_last;

    always_comb begin
        if (st == S_RST)                kind = K_RESET;
        else if (st == S_DATA && rd_q)  kind = K_READ;
        else                            kind = write_kind(sh_q[0]);
    end

    // next byte to load into the shifter
    always_comb begin
        sh_load = 1'b0;
        sh_val  = mem_q;
        case (st)
            S_IDLE:   begin sh_load = start;    sh_val = rom_cmd;     end
            S_ROM:    begin sh_load = byte_end; sh_val = sel_q ? addr_q[7:0] : mem_q; end
            S_ADDR:   begin
                sh_load = byte_end;
                sh_val  = (abyte == AW'(ADDR_BYTES - 1)) ? mem_q : addr_q[7:0];
            end
            S_WFETCH: begin sh_load = wr_valid; sh_val = wr_data;     end
            default:  ;
        endcase
        sh_shift = in_bits && eng_done;
    end

    owm_slot_engine #(
        .RST_LOW (RST_LOW),  .RST_REST(RST_REST), .PRES_AT(PRES_AT),
        .SLOT_LEN(SLOT_LEN), .W0_LOW  (W0_LOW),   .W1_LOW (W1_LOW),
        .RD_LOW  (RD_LOW),   .RD_AT   (RD_AT),    .MAX_LOW(MAX_LOW)
    ) u_slot (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .go       (go),
        .kind     (kind),
        .line_in  (line_in),
        .drive_low(line_pull_low),
        .slot_done(eng_done),
        .bit_q    (eng_bit),
        .pres_q   (eng_pres)
    );

    owm_bit_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (sh_load),
        .load_val(sh_val),
        .shift   (sh_shift),
        .shift_in(eng_bit),
        .q       (sh_q),
        .last_bit(sh_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            live      <= 1'b0;
            sel_q     <= 1'b0;
            rd_q      <= 1'b0;
            mem_q     <= '0;
            addr_q    <= '0;
            abyte     <= '0;
            left      <= '0;
            done_q    <= 1'b0;
            pres_hold <= 1'b0;
            nodev_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) live <= 1'b1;
            if (eng_done) live <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    sel_q     <= is_select(rom_cmd);
                    rd_q      <= rd_mode;
                    mem_q     <= mem_cmd;
                    addr_q    <= addr;
                    left      <= nbytes;
                    pres_hold <= 1'b0;
                    nodev_q   <= 1'b0;
                    st        <= S_RST;
                end
                S_RST: if (eng_done) begin
                    if (eng_pres) begin
                        pres_hold <= 1'b1;
                        st        <= S_ROM;
                    end else begin
                        nodev_q <= 1'b1;
                        done_q  <= 1'b1;
                        st      <= S_IDLE;
                    end
                end
                S_ROM: if (byte_end) begin
                    if (sel_q) begin
                        st     <= S_ADDR;
                        abyte  <= '0;
                        addr_q <= addr_q >> 8;
                    end else begin
                        st <= S_MEM;
                    end
                end
                S_ADDR: if (byte_end) begin
                    if (abyte == AW'(ADDR_BYTES - 1)) begin
                        st <= S_MEM;
                    end else begin
                        abyte  <= abyte + 1'b1;
                        addr_q <= addr_q >> 8;
                    end
                end
                S_MEM: if (byte_end) begin
                    if (left == '0) begin
                        done_q <= 1'b1;
                        st     <= S_IDLE;
                    end else begin
                        st <= rd_q ? S_DATA : S_WFETCH;
                    end
                end
                S_WFETCH: if (wr_valid) st <= S_DATA;
                S_DATA: if (byte_end) begin
                    if (rd_q) begin
                        st <= S_RHOLD;
                    end else begin
                        left <= left - 1'b1;
                        if (left == LEN_W'(1)) begin
                            done_q <= 1'b1;
                            st     <= S_IDLE;
                        end else begin
                            st <= S_WFETCH;
                        end
                    end
                end
                S_RHOLD: if (rd_ready) begin
                    left <= left - 1'b1;
                    if (left == LEN_W'(1)) begin
                        done_q <= 1'b1;
                        st     <= S_IDLE;
                    end else begin
                        st <= S_DATA;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign ready     = (st == S_IDLE);
    assign wr_ready  = (st == S_WFETCH);
    assign rd_valid  = (st == S_RHOLD);
    assign rd_data   = sh_q;
    assign done      = done_q;
    assign presence  = pres_hold;
    assign no_device = nodev_q;

    // R9
    stall_release_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ready || rd_valid) |-> !line_pull_low);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R11
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);

    // R3
    nodev_abort_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(no_device) |-> (done && !line_pull_low && !presence));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/tb_owire_txn_master.sv
module tb_owire_txn_master;
    import owm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  rom_cmd = '0;
    logic [7:0]  mem_cmd = '0;
    logic [63:0] addr = '0;
    logic        rd_mode = 1'b0;
    logic [7:0]  nbytes = '0;
    logic        ready;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic        line;
    logic        pull;
    logic        presence;
    logic        no_device;
    logic        done;

    always #4 clk = ~clk;

    owire_txn_master dut (
        .clk(clk), .rst(rst), .tick(tick), .start(start),
        .rom_cmd(rom_cmd), .mem_cmd(mem_cmd), .addr(addr),
        .rd_mode(rd_mode), .nbytes(nbytes), .ready(ready),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .line_in(line), .line_pull_low(pull), .presence(presence),
        .no_device(no_device), .done(done)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    bit          slave_here = 1'b1;
    bit          rd_txn = 1'b0;
    int          hdr_bits = 16;
    logic [31:0] rd_bytes = '0;
    int          cyc = 0;
    int          lowrun = 0;
    int          slot_t = 1000;
    int          pres_t = 0;
    int          bitpos = 0;
    int          rst_len = 0;
    int          bad_len = 0;
    int          max_low = 0;
    int          last_fall = -1;
    int          min_period = 1000000;
    bit          drv0 = 1'b0;
    logic        wbits [0:255];
    logic        s_pull;

    assign s_pull = (slave_here && pres_t >= 15 && pres_t < 115) ||
                    (drv0 && slot_t < 45);
    assign line = !(pull || s_pull);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pres_t != 0) pres_t <= (pres_t < 200) ? pres_t + 1 : 0;
        if (slot_t < 1000) slot_t <= slot_t + 1;
        if (pull) begin
            lowrun <= lowrun + 1;
            if (lowrun == 0) begin
                slot_t <= 1;
                if (last_fall >= 0 && cyc - last_fall < min_period)
                    min_period <= cyc - last_fall;
                last_fall <= cyc;
                drv0 <= rd_txn && bitpos >= hdr_bits && bitpos - hdr_bits < 32 &&
                        !rd_bytes[bitpos - hdr_bits];
            end
            if (lowrun + 1 == 400) begin
                bitpos    <= 0;
                last_fall <= -1;
            end
        end else begin
            if (lowrun != 0) begin
                if (lowrun >= 400) begin
                    rst_len <= lowrun;
                    pres_t  <= 1;
                end else begin
                    if (lowrun != 6 && lowrun != 60) bad_len <= bad_len + 1;
                    if (lowrun > max_low) max_low <= lowrun;
                end
            end
            lowrun <= 0;
        end
        if (slot_t == 30 && lowrun < 400) begin
            wbits[bitpos & 255] <= line;
            bitpos <= bitpos + 1;
        end
    end

    // ---------------- stimulus table ----------------
    typedef struct packed {
        logic [7:0]  rom;
        logic [7:0]  mem;
        logic        rd;
        logic [2:0]  n;
        logic [31:0] dat;
        logic [3:0]  stall;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{rom: 8'h55, mem: 8'hF0, rd: 1'b1, n: 3'd3, dat: 32'hA53C0F81, stall: 4'd5},
        '{rom: 8'hCC, mem: 8'h0F, rd: 1'b0, n: 3'd4, dat: 32'h12345678, stall: 4'd7},
        '{rom: 8'h55, mem: 8'hAA, rd: 1'b0, n: 3'd2, dat: 32'h0000C3E1, stall: 4'd0},
        '{rom: 8'hCC, mem: 8'h69, rd: 1'b1, n: 3'd0, dat: 32'h00000000, stall: 4'd0}
    };

    task automatic run_txn(input vec_t v, input int vi);
        int  k = 0;
        int  j = 0;
        int  sl = int'(v.stall);
        int  guard = 0;
        int  stall_bad = 0;
        int  bad = 0;
        int  idx = 0;
        bit  fin = 1'b0;
        logic [63:0] a = {v.dat, ~v.dat};
        rd_txn   = v.rd;
        rd_bytes = v.dat;
        hdr_bits = 16 + (v.rom == 8'h55 ? 64 : 0);
        @(negedge clk);
        rom_cmd = v.rom; mem_cmd = v.mem; addr = a;
        rd_mode = v.rd; nbytes = 8'(v.n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin && guard < 60000) begin
            @(negedge clk);
            guard++;
            if (done) fin = 1'b1;
            if ((wr_ready || rd_valid) && pull) stall_bad++;
            if (wr_valid) begin
                wr_valid = 1'b0;
                k++;
                sl = int'(v.stall);
            end else if (wr_ready) begin
                if (sl > 0) sl--;
                else begin
                    wr_data  = v.dat[8*k +: 8];
                    wr_valid = 1'b1;
                end
            end
            if (rd_ready) begin
                rd_ready = 1'b0;
                j++;
                sl = int'(v.stall);
            end else if (rd_valid) begin
                if (sl > 0) sl--;
                else begin
                    // R8 read byte assembled from slave bits
                    check(rd_data == v.dat[8*j +: 8], "R8", $sformatf("vec%0d read byte %0d", vi, j),
                          rd_data, v.dat[8*j +: 8]);
                    rd_ready = 1'b1;
                end
            end
        end
        if (!fin) check(1'b0, "R11", "watchdog on transaction", guard, 0);
        repeat (3) @(negedge clk);
        check(presence == 1'b1 && no_device == 1'b0, "R2", $sformatf("vec%0d presence", vi),
              presence, 1);
        check(bitpos == hdr_bits + 8*int'(v.n), "R6", $sformatf("vec%0d slot count", vi),
              bitpos, hdr_bits + 8*int'(v.n));
        for (int i = 0; i < 8; i++) if (wbits[i] !== v.rom[i]) bad++;
        check(bad == 0, "R5", $sformatf("vec%0d device command bits", vi), bad, 0);
        idx = 8; bad = 0;
        if (v.rom == 8'h55) begin
            for (int i = 0; i < 64; i++) if (wbits[idx + i] !== a[i]) bad++;
            idx += 64;
            check(bad == 0, "R5", $sformatf("vec%0d address bits", vi), bad, 0);
            bad = 0;
        end
        for (int i = 0; i < 8; i++) if (wbits[idx + i] !== v.mem[i]) bad++;
        idx += 8;
        check(bad == 0, "R6", $sformatf("vec%0d memory command bits", vi), bad, 0);
        if (!v.rd) begin
            bad = 0;
            for (int i = 0; i < 8*int'(v.n); i++) if (wbits[idx + i] !== v.dat[i]) bad++;
            check(bad == 0 && k == int'(v.n), "R7", $sformatf("vec%0d write data bits", vi), bad, 0);
        end else begin
            check(j == int'(v.n), "R8", $sformatf("vec%0d read bytes taken", vi), j, v.n);
        end
        check(stall_bad == 0, "R9", $sformatf("vec%0d line released in stall", vi), stall_bad, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            check(1'b0, "R11", "global watchdog", cyc, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ready && !pull && !done && !wr_ready && !rd_valid, "R1", "reset outputs",
              {ready, pull, done, wr_ready, rd_valid}, 5'b10000);

        for (int vi = 0; vi < NV; vi++) run_txn(VECS[vi], vi);

        // R2 reset low length
        check(rst_len == 480, "R2", "reset low length", rst_len, 480);
        // R4 slot shapes and spacing
        check(bad_len == 0, "R4", "slot low lengths", bad_len, 0);
        check(min_period >= 70, "R4", "slot spacing", min_period, 70);
        // R10 longest data low
        check(max_low < 120, "R10", "longest slot low", max_low, 60);

        // R11 back-to-back: start held across done; R3 with no slave
        slave_here = 1'b0;
        rd_txn = 1'b0;
        @(negedge clk);
        rom_cmd = 8'hCC; mem_cmd = 8'hF0; nbytes = 8'd1; rd_mode = 1'b0;
        start = 1'b1;
        g = 0;
        while (!done && g < 5000) begin @(negedge clk); g++; end
        check(done && ready, "R11", "ready in done cycle", ready, 1);
        check(no_device == 1'b1, "R3", "no_device after silent reset", no_device, 1);
        @(negedge clk);
        start = 1'b0;
        check(!ready, "R11", "start taken in done cycle", ready, 0);
        g = 0;
        while (!done && g < 5000) begin @(negedge clk); g++; end
        check(done && no_device && !presence, "R3", "second abort flags", no_device, 1);
        check(bitpos == 0, "R3", "no slots after abort", bitpos, 0);
        check(rst_len == 480, "R2", "reset low length back-to-back", rst_len, 480);
        g = 0;
        repeat (20) begin @(negedge clk); if (pull) g++; end
        check(g == 0 && ready, "R3", "line released after abort", g, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule